// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a two-part logical address, a segment number plus an offset inside that segment, into a physical address. It holds a small segment table on chip. Each table entry keeps four things: the physical start address of the segment, the segment length, a valid flag, and three permission flags for read, write and execute. Privileged software fills the table through a write port. A separate input gives the number of segments the current program uses.

Each request carries a segment number, an offset, an access type and a supervisor flag. In user mode the block runs four checks in a fixed order of priority: the segment count, the entry valid flag, the offset against the length, and the permission for the access type. If all four pass, it returns base plus offset. If a check fails, it returns a non-zero fault code that names the first failed check, so the surrounding logic can raise a trap and issue no memory access. In supervisor mode the checks are skipped and the address passes through untranslated.

The result is registered. It appears one cycle after the request is accepted, and a valid/ready handshake on both sides lets the consumer stall the block.

Top module: `seg_translator`

## Requirements
- R1: A request is accepted when `req_valid` and `req_ready` are both high, and `req_ready` equals `!rsp_valid || rsp_ready`. The response is presented on the cycle after acceptance. While `rsp_valid` is high and `rsp_ready` is low, the response is held unchanged.
- R2: A user-mode access that passes every check returns `rsp_code` 0 and `rsp_paddr` = entry base + zero-extended offset, taken modulo 2^PA_W.
- R3: In user mode, a segment number greater than or equal to `seg_count` returns code 1 (segment out of range). This check has the highest priority.
- R4: In user mode, an in-range segment whose entry valid flag is 0 returns code 2 (invalid entry). This check ranks second.
- R5: In user mode, an offset greater than or equal to the entry length returns code 3 (offset over limit). This check ranks third.
- R6: In user mode, the access type selects one permission bit: type 0 (read) uses bit 0, type 1 (write) uses bit 1, and type 2 (execute) uses bit 2. Type 3 is always refused. A refused access returns code 4 (permission denied), which ranks last.
- R7: A response with a non-zero code has `rsp_paddr` = 0 and `rsp_fault` = 1. A response with code 0 has `rsp_fault` = 0.
- R8: A supervisor request (`req_super` = 1) returns code 0 and `rsp_paddr` = {zeros, segment, offset}, whatever the table holds and whatever `seg_count` is.
- R9: A table write takes effect at the clock edge that samples it. A request accepted at that same edge still sees the old entry, and requests accepted later see the new one.
- R10: After reset, `rsp_valid` is 0, `req_ready` is 1, and every table entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | SEG_W | Entry index to write |
| tbl_wr_base | input | PA_W | Segment start physical address |
| tbl_wr_limit | input | OFF_W | Segment length |
| tbl_wr_valid | input | 1 | Entry valid flag |
| tbl_wr_perm | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| seg_count | input | SEG_W+1 | Number of segments in use |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| req_super | input | 1 | Supervisor mode, bypasses checks |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes response |
| rsp_paddr | output | PA_W | Physical address (0 on fault) |
| rsp_fault | output | 1 | Any check failed |
| rsp_code | output | 3 | 0 ok, 1 range, 2 invalid, 3 limit, 4 permission |

## Verification
The table is loaded with entries that differ in base, length, valid flag and permissions. A table of user requests then drives each entry at offsets inside, at, and past its length, with every access type. This separates a correct sum from a wrong operand or a lost carry, and tells the limit check apart from an off-by-one compare. Requests that fail two checks at once show that the priority order is right. Supervisor requests to invalid and out-of-range segments show that the bypass ignores the table. Directed sequences cover the reset state, back-pressure holding a response, a write that lands in the same cycle as a lookup, and a lowered segment count.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [2:0] {
      FLT_NONE      = 3'd0,
      FLT_SEG_RANGE = 3'd1,
      FLT_INVALID   = 3'd2,
      FLT_LIMIT     = 3'd3,
      FLT_PERM      = 3'd4
   } flt_e;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   localparam int PERM_W = 3;
   localparam int PERM_R = 0;
   localparam int PERM_WR = 1;
   localparam int PERM_X = 2;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
   parameter int SEG_COUNT = 16,
   parameter int OFF_W     = 16,
   parameter int PA_W      = 32,
   localparam int SEG_W    = $clog2(SEG_COUNT)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [SEG_W-1:0]                  wr_idx,
   input  logic [PA_W-1:0]                   wr_base,
   input  logic [OFF_W-1:0]                  wr_limit,
   input  logic                              wr_valid,
   input  logic [seg_xlate_pkg::PERM_W-1:0]  wr_perm,
   input  logic [SEG_W-1:0]                  rd_idx,
   output logic [PA_W-1:0]                   rd_base,
   output logic [OFF_W-1:0]                  rd_limit,
   output logic                              rd_valid,
   output logic [seg_xlate_pkg::PERM_W-1:0]  rd_perm
);
   import seg_xlate_pkg::*;

   initial begin
      assert (SEG_COUNT >= 2) else $error("seg_table: SEG_COUNT must be at least 2");
   end

   logic [PA_W-1:0]   base_q  [SEG_COUNT];
   logic [OFF_W-1:0]  limit_q [SEG_COUNT];
   logic              vld_q   [SEG_COUNT];
   logic [PERM_W-1:0] perm_q  [SEG_COUNT];

   for (genvar g = 0; g < SEG_COUNT; g++) begin : g_entry
      logic hit_w;
      assign hit_w = wr_en && (wr_idx == SEG_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[g]  <= '0;
            limit_q[g] <= '0;
            vld_q[g]   <= 1'b0;
            perm_q[g]  <= '0;
         end else if (hit_w) begin
            base_q[g]  <= wr_base;
            limit_q[g] <= wr_limit;
            vld_q[g]   <= wr_valid;
            perm_q[g]  <= wr_perm;
         end
      end
   end

   always_comb begin
      rd_base  = '0;
      rd_limit = '0;
      rd_valid = 1'b0;
      rd_perm  = '0;
      for (int i = 0; i < SEG_COUNT; i++) begin
         if (rd_idx == SEG_W'(i)) begin
            rd_base  = base_q[i];
            rd_limit = limit_q[i];
            rd_valid = vld_q[i];
            rd_perm  = perm_q[i];
         end
      end
   end

endmodule

// File: rtl/seg_check.sv
module seg_check #(
   parameter int SEG_COUNT   = 16,
   parameter int OFF_W       = 16,
   parameter int PA_W        = 32,
   parameter bit SUPER_BYPASS = 1'b1,
   localparam int SEG_W      = $clog2(SEG_COUNT)
) (
   input  logic [SEG_W-1:0]                  seg,
   input  logic [OFF_W-1:0]                  off,
   input  logic [1:0]                        acc,
   input  logic                              super_mode,
   input  logic [SEG_W:0]                    seg_count,
   input  logic [PA_W-1:0]                   ent_base,
   input  logic [OFF_W-1:0]                  ent_limit,
   input  logic                              ent_valid,
   input  logic [seg_xlate_pkg::PERM_W-1:0]  ent_perm,
   output logic [PA_W-1:0]                   paddr,
   output seg_xlate_pkg::flt_e               code
);
   import seg_xlate_pkg::*;

   localparam int PAD_OFF = PA_W - OFF_W;
   localparam int PAD_RAW = PA_W - SEG_W - OFF_W;

   initial begin
      assert (PA_W >= SEG_W + OFF_W) else $error("seg_check: PA_W too narrow for pass-through");
   end

   logic            range_bad, perm_ok;
   logic [PA_W-1:0] sum_w, raw_w;
   flt_e            user_code;

   assign sum_w = ent_base + {{PAD_OFF{1'b0}}, off};
   if (PAD_RAW > 0) begin : g_raw_pad
      assign raw_w = {{PAD_RAW{1'b0}}, seg, off};
   end else begin : g_raw_nopad
      assign raw_w = {seg, off};
   end

   assign range_bad = ({1'b0, seg} >= seg_count) || ({1'b0, seg} >= (SEG_W+1)'(SEG_COUNT));

   always_comb begin
      case (acc_e'(acc))
         ACC_READ:  perm_ok = ent_perm[PERM_R];
         ACC_WRITE: perm_ok = ent_perm[PERM_WR];
         ACC_EXEC:  perm_ok = ent_perm[PERM_X];
         default:   perm_ok = 1'b0;
      endcase
   end

   always_comb begin
      if (range_bad)               user_code = FLT_SEG_RANGE;
      else if (!ent_valid)         user_code = FLT_INVALID;
      else if (off >= ent_limit)   user_code = FLT_LIMIT;
      else if (!perm_ok)           user_code = FLT_PERM;
      else                         user_code = FLT_NONE;
   end

   if (SUPER_BYPASS) begin : g_bypass
      always_comb begin
         if (super_mode) begin
            code  = FLT_NONE;
            paddr = raw_w;
         end else begin
            code  = user_code;
            paddr = (user_code == FLT_NONE) ? sum_w : '0;
         end
      end
   end else begin : g_always_check
      always_comb begin
         code  = user_code;
         paddr = (user_code == FLT_NONE) ? sum_w : '0;
      end
   end

endmodule

// File: rtl/seg_resp_reg.sv
module seg_resp_reg #(
   parameter int PA_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [PA_W-1:0]      in_paddr,
   input  seg_xlate_pkg::flt_e  in_code,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [PA_W-1:0]      out_paddr,
   output seg_xlate_pkg::flt_e  out_code
);
   import seg_xlate_pkg::*;

   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_paddr <= '0;
         out_code  <= FLT_NONE;
      end else if (in_ready) begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_paddr <= in_paddr;
            out_code  <= in_code;
         end
      end
   end

   // R1: a stalled response stays put
   a_r1_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_paddr) && $stable(out_code)));

   // R1: an accepted request shows up on the next cycle
   a_r1_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

endmodule

// File: rtl/seg_translator.sv
module seg_translator #(
   parameter int SEG_COUNT    = 16,
   parameter int OFF_W        = 16,
   parameter int PA_W         = 32,
   parameter bit SUPER_BYPASS = 1'b1,
   localparam int SEG_W       = $clog2(SEG_COUNT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tbl_wr_en,
   input  logic [SEG_W-1:0]   tbl_wr_idx,
   input  logic [PA_W-1:0]    tbl_wr_base,
   input  logic [OFF_W-1:0]   tbl_wr_limit,
   input  logic               tbl_wr_valid,
   input  logic [2:0]         tbl_wr_perm,
   input  logic [SEG_W:0]     seg_count,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [SEG_W-1:0]   req_seg,
   input  logic [OFF_W-1:0]   req_off,
   input  logic [1:0]         req_acc,
   input  logic               req_super,
   output logic               rsp_valid,
   input  logic               rsp_ready,
   output logic [PA_W-1:0]    rsp_paddr,
   output logic               rsp_fault,
   output logic [2:0]         rsp_code
);
   import seg_xlate_pkg::*;

   initial begin
      assert (OFF_W >= 1 && OFF_W < PA_W) else $error("seg_translator: OFF_W out of range");
   end

   logic [PA_W-1:0]   ent_base;
   logic [OFF_W-1:0]  ent_limit;
   logic              ent_valid;
   logic [PERM_W-1:0] ent_perm;
   logic [PA_W-1:0]   chk_paddr;
   flt_e              chk_code, out_code;

   seg_table #(.SEG_COUNT(SEG_COUNT), .OFF_W(OFF_W), .PA_W(PA_W)) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx), .wr_base(tbl_wr_base),
      .wr_limit(tbl_wr_limit), .wr_valid(tbl_wr_valid), .wr_perm(tbl_wr_perm),
      .rd_idx(req_seg), .rd_base(ent_base), .rd_limit(ent_limit),
      .rd_valid(ent_valid), .rd_perm(ent_perm)
   );

   seg_check #(.SEG_COUNT(SEG_COUNT), .OFF_W(OFF_W), .PA_W(PA_W),
               .SUPER_BYPASS(SUPER_BYPASS)) u_check (
      .seg(req_seg), .off(req_off), .acc(req_acc), .super_mode(req_super),
      .seg_count(seg_count), .ent_base(ent_base), .ent_limit(ent_limit),
      .ent_valid(ent_valid), .ent_perm(ent_perm),
      .paddr(chk_paddr), .code(chk_code)
   );

   seg_resp_reg #(.PA_W(PA_W)) u_resp (
      .clk(clk), .rst_n(rst_n),
      .in_valid(req_valid), .in_ready(req_ready),
      .in_paddr(chk_paddr), .in_code(chk_code),
      .out_valid(rsp_valid), .out_ready(rsp_ready),
      .out_paddr(rsp_paddr), .out_code(out_code)
   );

   assign rsp_code  = out_code;
   assign rsp_fault = (out_code != FLT_NONE);

   // R3: out-of-range segment wins over every other fault
   a_r3_range_first: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_super && ({1'b0, req_seg} >= seg_count))
      |=> (rsp_code == 3'd1));

   // R7: a faulting response never carries an address
   a_r7_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

   // R8: supervisor requests never fault
   a_r8_super_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (SUPER_BYPASS && req_valid && req_ready && req_super) |=> (rsp_code == 3'd0));

   // R6: reserved access type never succeeds in user mode
   a_r6_rsvd_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_super && req_acc == 2'd3) |=> (rsp_code != 3'd0));

endmodule

// File: tb/seg_translator_bench.sv
module seg_translator_bench;

   localparam int CLK_PERIOD = 10;
   localparam int VW = 1 + 2 + 4 + 16 + 3 + 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tbl_wr_en = 1'b0;
   logic [3:0]  tbl_wr_idx = '0;
   logic [31:0] tbl_wr_base = '0;
   logic [15:0] tbl_wr_limit = '0;
   logic        tbl_wr_valid = 1'b0;
   logic [2:0]  tbl_wr_perm = '0;
   logic [4:0]  seg_count = 5'd4;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [3:0]  req_seg = '0;
   logic [15:0] req_off = '0;
   logic [1:0]  req_acc = '0;
   logic        req_super = 1'b0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b1;
   logic [31:0] rsp_paddr;
   logic        rsp_fault;
   logic [2:0]  rsp_code;

   int errors = 0;
   int checks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   seg_translator u_seg_translator (
      .clk(clk), .rst_n(rst_n),
      .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_base(tbl_wr_base),
      .tbl_wr_limit(tbl_wr_limit), .tbl_wr_valid(tbl_wr_valid), .tbl_wr_perm(tbl_wr_perm),
      .seg_count(seg_count),
      .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg), .req_off(req_off),
      .req_acc(req_acc), .req_super(req_super),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
      .rsp_fault(rsp_fault), .rsp_code(rsp_code)
   );

   // {super, acc, seg, off, code, paddr}
   localparam logic [VW-1:0] VEC [16] = '{
      {1'b0, 2'd0, 4'd0,  16'h0010, 3'd0, 32'h1000_0010},   // R2 read in range
      {1'b0, 2'd1, 4'd0,  16'h00FF, 3'd0, 32'h1000_00FF},   // R2 R5 last legal offset
      {1'b0, 2'd0, 4'd0,  16'h0100, 3'd3, 32'h0},           // R5 offset equals length
      {1'b0, 2'd2, 4'd0,  16'h0000, 3'd4, 32'h0},           // R6 exec refused
      {1'b0, 2'd2, 4'd1,  16'h7FFF, 3'd0, 32'h2000_7FFF},   // R6 exec allowed
      {1'b0, 2'd0, 4'd1,  16'h0000, 3'd4, 32'h0},           // R6 read refused
      {1'b0, 2'd1, 4'd1,  16'h0004, 3'd4, 32'h0},           // R6 write refused
      {1'b0, 2'd0, 4'd2,  16'h0000, 3'd2, 32'h0},           // R4 invalid entry
      {1'b0, 2'd0, 4'd4,  16'h0000, 3'd1, 32'h0},           // R3 seg == count
      {1'b0, 2'd3, 4'd15, 16'hFFFF, 3'd1, 32'h0},           // R3 top segment
      {1'b0, 2'd1, 4'd3,  16'hFFFE, 3'd0, 32'h0001_EFFE},   // R2 carry into upper bits
      {1'b0, 2'd3, 4'd3,  16'h0000, 3'd4, 32'h0},           // R6 reserved type
      {1'b0, 2'd2, 4'd2,  16'hFFFF, 3'd2, 32'h0},           // R4 before limit/perm
      {1'b0, 2'd2, 4'd0,  16'h0200, 3'd3, 32'h0},           // R5 before perm
      {1'b1, 2'd2, 4'd7,  16'h1234, 3'd0, 32'h0007_1234},   // R8 bypass, out of range
      {1'b1, 2'd0, 4'd2,  16'hFFFF, 3'd0, 32'h0002_FFFF}    // R8 bypass, invalid entry
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_entry(input logic [3:0] idx, input logic [31:0] base,
                           input logic [15:0] lim, input logic vld, input logic [2:0] perm);
      @(negedge clk);
      tbl_wr_en = 1'b1; tbl_wr_idx = idx; tbl_wr_base = base;
      tbl_wr_limit = lim; tbl_wr_valid = vld; tbl_wr_perm = perm;
      @(negedge clk);
      tbl_wr_en = 1'b0;
   endtask

   // drive for one edge; on return the response is visible
   task automatic issue(input logic sup, input logic [1:0] acc,
                        input logic [3:0] seg, input logic [15:0] off);
      @(negedge clk);
      req_valid = 1'b1; req_super = sup; req_acc = acc; req_seg = seg; req_off = off;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10 reset state
      chk("R10 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
      chk("R10 req_ready after reset", {31'b0, req_ready}, 32'd1);
      rst_n = 1'b1;
      issue(1'b0, 2'd0, 4'd0, 16'h0000);
      chk("R10 entries invalid after reset", {29'b0, rsp_code}, 32'd2);

      wr_entry(4'd0, 32'h1000_0000, 16'h0100, 1'b1, 3'b011);
      wr_entry(4'd1, 32'h2000_0000, 16'h8000, 1'b1, 3'b100);
      wr_entry(4'd2, 32'h3000_0000, 16'hFFFF, 1'b0, 3'b111);
      wr_entry(4'd3, 32'h0000_F000, 16'hFFFF, 1'b1, 3'b111);

      for (int i = 0; i < 16; i++) begin
         logic [VW-1:0] v;
         v = VEC[i];
         issue(v[57], v[56:55], v[54:51], v[50:35]);
         chk($sformatf("R1 vec%0d valid", i), {31'b0, rsp_valid}, 32'd1);
         chk($sformatf("R2-code vec%0d", i), {29'b0, rsp_code}, {29'b0, v[34:32]});
         chk($sformatf("R2-addr vec%0d", i), rsp_paddr, v[31:0]);
         chk($sformatf("R7 vec%0d fault flag", i), {31'b0, rsp_fault}, {31'b0, (v[34:32] != 3'd0)});
      end

      // R1 back-pressure
      @(negedge clk);
      rsp_ready = 1'b0;
      issue(1'b0, 2'd0, 4'd0, 16'h0020);
      chk("R1 stalled valid", {31'b0, rsp_valid}, 32'd1);
      chk("R1 ready low while stalled", {31'b0, req_ready}, 32'd0);
      req_valid = 1'b1; req_super = 1'b0; req_acc = 2'd1; req_seg = 4'd3; req_off = 16'h0001;
      repeat (2) @(negedge clk);
      chk("R1 held address", rsp_paddr, 32'h1000_0020);
      rsp_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R1 next after release", rsp_paddr, 32'h0000_F001);
      @(negedge clk);
      chk("R1 drained", {31'b0, rsp_valid}, 32'd0);

      // R9 write and lookup in the same cycle
      @(negedge clk);
      tbl_wr_en = 1'b1; tbl_wr_idx = 4'd0; tbl_wr_base = 32'h4000_0000;
      tbl_wr_limit = 16'h0100; tbl_wr_valid = 1'b1; tbl_wr_perm = 3'b001;
      req_valid = 1'b1; req_super = 1'b0; req_acc = 2'd0; req_seg = 4'd0; req_off = 16'h0005;
      @(negedge clk);
      tbl_wr_en = 1'b0; req_valid = 1'b0;
      chk("R9 same-cycle sees old base", rsp_paddr, 32'h1000_0005);
      issue(1'b0, 2'd0, 4'd0, 16'h0005);
      chk("R9 later sees new base", rsp_paddr, 32'h4000_0005);
      issue(1'b0, 2'd1, 4'd0, 16'h0005);
      chk("R9 new perms apply", {29'b0, rsp_code}, 32'd4);

      // R3 lowered segment count
      seg_count = 5'd1;
      issue(1'b0, 2'd2, 4'd1, 16'h0000);
      chk("R3 count lowered", {29'b0, rsp_code}, 32'd1);
      seg_count = 5'd0;
      issue(1'b0, 2'd0, 4'd0, 16'h0000);
      chk("R3 zero count", {29'b0, rsp_code}, 32'd1);
      issue(1'b1, 2'd1, 4'd0, 16'h00AA);
      chk("R8 bypass with zero count", rsp_paddr, 32'h0000_00AA);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule